// File: doc/BRIEF.md
# Two-stage SCL rate generator

This block derives the serial clock timing for an I2C master from a fast peripheral clock. A prescaler divides the input clock by one plus a 3-bit divisor to give an internal tick enable. A period stage then counts ticks: one SCL period lasts a fixed base of 20 ticks, plus 8 ticks for every step of a 6-bit step field, plus an edge-compensation count. The compensation count covers the SCL fall time, the SCL rise time and the internal delay. The period splits into a low phase and a high phase. When the period has an odd length, the low phase takes the extra tick.

The byte engine starts the generator with a START request. It stops the generator with a stop request, which takes effect only when the current period has completed. The engine follows the phase strobes to move SDA and to sample it. The configuration word can be written at any time, but it is applied only at the next START, so an SCL period in progress is never shortened. An optional setup delay holds SCL high for 17 ticks after START, before the first low phase.

Top module: `i2c_scl_gen`

## Requirements
- R1: During reset and after it, until a START, `scl_o` is 1 and `tick_o`, `scl_low_o` and `scl_high_o` are 0.
- R2: While the generator runs, `tick_o` is high for one cycle in every CDF+1 cycles. The first tick comes CDF+1 cycles after the START edge. No tick is issued while the generator is idle.
- R3: One SCL period is P = 20 + 8*SCGD + COMP ticks. The low phase lasts ceil(P/2) ticks and the high phase lasts floor(P/2) ticks, that is (CDF+1) times as many clock cycles.
- R4: The configuration word carries CDF in bits [2:0] and SCGD in bits [8:3]. The full ranges 0..7 and 0..63 are honoured.
- R5: A configuration write made while the generator runs has no effect on the running periods. It is applied at the next START.
- R6: If `setup_en_i` is high at START, SCL stays high for 17 ticks before the first low phase. Later periods carry no setup delay.
- R7: A stop request, whether it arrives in the low phase or in the high phase, lets the current period complete in full. The generator then goes idle with SCL high and issues no further low phase.
- R8: A START that arrives while the generator runs is ignored. The current phase keeps its length.
- R9: `scl_low_o` and `scl_high_o` are one-cycle pulses, asserted in the first cycle in which `scl_o` shows the new level. They are never asserted together. When START has no setup delay, `scl_low_o` is asserted in the cycle after START.
- R10: `comp_i` is sampled at START. A change to it while the generator runs does not alter the running periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 9 | Configuration word: CDF in [2:0], SCGD in [8:3] |
| cfg_we_i | input | 1 | Writes `cfg_i` into the pending configuration |
| comp_i | input | 5 | Edge-compensation ticks, sampled at START |
| setup_en_i | input | 1 | Enables the 17-tick first-edge setup delay, sampled at START |
| start_i | input | 1 | START request, accepted only when idle |
| stop_i | input | 1 | Stop request, honoured at the end of the current period |
| tick_o | output | 1 | Internal tick enable |
| scl_o | output | 1 | SCL level, 1 when idle |
| scl_low_o | output | 1 | Strobe in the first cycle of each low phase |
| scl_high_o | output | 1 | Strobe in the first cycle of each high phase |

## Verification
The bound checker watches the tick spacing against the active divisor and confirms that no tick appears while idle. It also counts the ticks in each low phase against the active period, and checks that the strobes line up with the SCL edges. In addition, it confirms that the active configuration cannot change during a run. Only the directed scenarios can show the behaviour across several runs. These cover the deferral of a configuration written mid-run, the rejection of a START while running, the full-length finish after a stop, the one-time setup delay, and the exact high-phase lengths at the field extremes.

// File: rtl/i2c_sclgen_pkg.sv
`timescale 1ns/1ps
package i2c_sclgen_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_LOW   = 2'd2,
    PH_HIGH  = 2'd3
  } scl_phase_e;

  // longest period in ticks for the given field widths
  function automatic int per_max(input int base, input int step,
                                 input int scgd_w, input int comp_w);
    return base + step * ((1 << scgd_w) - 1) + ((1 << comp_w) - 1);
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/i2c_sclgen_cfg.sv
`timescale 1ns/1ps
module i2c_sclgen_cfg #(
  parameter int CDF_W  = 3,
  parameter int SCGD_W = 6,
  parameter int COMP_W = 5,
  localparam int CFG_W = CDF_W + SCGD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic              cfg_we_i,
  input  logic [COMP_W-1:0] comp_i,
  input  logic              load_i,
  output logic [CDF_W-1:0]  cdf_o,
  output logic [SCGD_W-1:0] scgd_o,
  output logic [COMP_W-1:0] comp_o
);

  logic [CFG_W-1:0]  pend_q;
  logic [CFG_W-1:0]  next_cfg;
  logic [CDF_W-1:0]  cdf_q;
  logic [SCGD_W-1:0] scgd_q;
  logic [COMP_W-1:0] comp_q;

  // a write in the START cycle is the one applied
  assign next_cfg = cfg_we_i ? cfg_i : pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
    end else if (cfg_we_i) begin
      pend_q <= cfg_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cdf_q  <= '0;
      scgd_q <= '0;
      comp_q <= '0;
    end else if (load_i) begin
      cdf_q  <= next_cfg[CDF_W-1:0];
      scgd_q <= next_cfg[CFG_W-1:CDF_W];
      comp_q <= comp_i;
    end
  end

  assign cdf_o  = cdf_q;
  assign scgd_o = scgd_q;
  assign comp_o = comp_q;

endmodule

// File: rtl/i2c_sclgen_prescale.sv
`timescale 1ns/1ps
module i2c_sclgen_prescale #(
  parameter int CDF_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CDF_W-1:0] cdf_i,
  output logic             tick_o
);

  logic [CDF_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == cdf_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_i || tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CDF_W'(1);
    end
  end

endmodule

// File: rtl/i2c_sclgen_period.sv
`timescale 1ns/1ps
module i2c_sclgen_period #(
  parameter int SCGD_W     = 6,
  parameter int COMP_W     = 5,
  parameter int BASE_TICKS = 20,
  parameter int STEP_TICKS = 8,
  parameter int PER_W      = 10
) (
  input  logic [SCGD_W-1:0] scgd_i,
  input  logic [COMP_W-1:0] comp_i,
  output logic [PER_W-1:0]  low_len_o,
  output logic [PER_W-1:0]  high_len_o
);

  localparam logic [PER_W-1:0] BASE_C = PER_W'(BASE_TICKS);

  logic [PER_W-1:0] step_part;
  logic [PER_W-1:0] per;

  generate
    if ((STEP_TICKS & (STEP_TICKS - 1)) == 0) begin : g_step_shift
      localparam int SHIFT = $clog2(STEP_TICKS);
      assign step_part = PER_W'(scgd_i) << SHIFT;
    end else begin : g_step_mul
      assign step_part = PER_W'(scgd_i) * PER_W'(STEP_TICKS);
    end
  endgenerate

  assign per        = BASE_C + step_part + PER_W'(comp_i);
  // odd tick goes to the low phase
  assign low_len_o  = (per + PER_W'(1)) >> 1;
  assign high_len_o = per >> 1;

endmodule

// File: rtl/i2c_sclgen_phase.sv
`timescale 1ns/1ps
module i2c_sclgen_phase
  import i2c_sclgen_pkg::*;
#(
  parameter int PER_W       = 10,
  parameter int SETUP_TICKS = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             setup_en_i,
  input  logic             tick_i,
  input  logic [PER_W-1:0] low_len_i,
  input  logic [PER_W-1:0] high_len_i,
  output logic             idle_o,
  output logic             scl_o,
  output logic             low_stb_o,
  output logic             high_stb_o
);

  localparam logic [PER_W-1:0] SETUP_LAST = PER_W'(SETUP_TICKS - 1);

  scl_phase_e       state_q;
  logic [PER_W-1:0] cnt_q;
  logic             stop_q;
  logic             low_stb_q;
  logic             high_stb_q;
  logic [PER_W-1:0] low_last;
  logic [PER_W-1:0] high_last;

  assign low_last  = low_len_i - PER_W'(1);
  assign high_last = high_len_i - PER_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= PH_IDLE;
      cnt_q      <= '0;
      stop_q     <= 1'b0;
      low_stb_q  <= 1'b0;
      high_stb_q <= 1'b0;
    end else begin
      low_stb_q  <= 1'b0;
      high_stb_q <= 1'b0;
      if (stop_i && (state_q != PH_IDLE)) stop_q <= 1'b1;
      unique case (state_q)
        PH_IDLE: begin
          stop_q <= 1'b0;
          cnt_q  <= '0;
          if (start_i) begin
            if (setup_en_i) begin
              state_q <= PH_SETUP;
            end else begin
              state_q   <= PH_LOW;
              low_stb_q <= 1'b1;
            end
          end
        end
        PH_SETUP: begin
          if (tick_i) begin
            if (cnt_q == SETUP_LAST) begin
              cnt_q     <= '0;
              state_q   <= PH_LOW;
              low_stb_q <= 1'b1;
            end else begin
              cnt_q <= cnt_q + PER_W'(1);
            end
          end
        end
        PH_LOW: begin
          if (tick_i) begin
            if (cnt_q == low_last) begin
              cnt_q      <= '0;
              state_q    <= PH_HIGH;
              high_stb_q <= 1'b1;
            end else begin
              cnt_q <= cnt_q + PER_W'(1);
            end
          end
        end
        PH_HIGH: begin
          if (tick_i) begin
            if (cnt_q == high_last) begin
              cnt_q <= '0;
              // a stop is honoured only once the period has completed
              if (stop_q || stop_i) begin
                state_q <= PH_IDLE;
              end else begin
                state_q   <= PH_LOW;
                low_stb_q <= 1'b1;
              end
            end else begin
              cnt_q <= cnt_q + PER_W'(1);
            end
          end
        end
        default: state_q <= PH_IDLE;
      endcase
    end
  end

  assign idle_o     = (state_q == PH_IDLE);
  assign scl_o      = (state_q != PH_LOW);
  assign low_stb_o  = low_stb_q;
  assign high_stb_o = high_stb_q;

endmodule

// File: rtl/i2c_scl_gen.sv
`timescale 1ns/1ps
module i2c_scl_gen
  import i2c_sclgen_pkg::*;
#(
  parameter int CDF_W       = 3,
  parameter int SCGD_W      = 6,
  parameter int COMP_W      = 5,
  parameter int BASE_TICKS  = 20,
  parameter int STEP_TICKS  = 8,
  parameter int SETUP_TICKS = 17,
  localparam int CFG_W      = CDF_W + SCGD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic              cfg_we_i,
  input  logic [COMP_W-1:0] comp_i,
  input  logic              setup_en_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic              tick_o,
  output logic              scl_o,
  output logic              scl_low_o,
  output logic              scl_high_o
);

  localparam int PER_BITS = $clog2(per_max(BASE_TICKS, STEP_TICKS, SCGD_W, COMP_W) + 2);
  localparam int SET_BITS = $clog2(SETUP_TICKS + 1);
  localparam int CNT_W    = imax(PER_BITS, SET_BITS);

  logic              idle;
  logic              run;
  logic              start_ok;
  logic [CDF_W-1:0]  act_cdf;
  logic [SCGD_W-1:0] act_scgd;
  logic [COMP_W-1:0] act_comp;
  logic [CNT_W-1:0]  low_len;
  logic [CNT_W-1:0]  high_len;

  assign run      = !idle;
  assign start_ok = start_i && idle;

  i2c_sclgen_cfg #(
    .CDF_W (CDF_W),
    .SCGD_W(SCGD_W),
    .COMP_W(COMP_W)
  ) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cfg_i   (cfg_i),
    .cfg_we_i(cfg_we_i),
    .comp_i  (comp_i),
    .load_i  (start_ok),
    .cdf_o   (act_cdf),
    .scgd_o  (act_scgd),
    .comp_o  (act_comp)
  );

  i2c_sclgen_prescale #(
    .CDF_W(CDF_W)
  ) u_prescale (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .cdf_i (act_cdf),
    .tick_o(tick_o)
  );

  i2c_sclgen_period #(
    .SCGD_W    (SCGD_W),
    .COMP_W    (COMP_W),
    .BASE_TICKS(BASE_TICKS),
    .STEP_TICKS(STEP_TICKS),
    .PER_W     (CNT_W)
  ) u_period (
    .scgd_i    (act_scgd),
    .comp_i    (act_comp),
    .low_len_o (low_len),
    .high_len_o(high_len)
  );

  i2c_sclgen_phase #(
    .PER_W      (CNT_W),
    .SETUP_TICKS(SETUP_TICKS)
  ) u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .stop_i    (stop_i),
    .setup_en_i(setup_en_i),
    .tick_i    (tick_o),
    .low_len_i (low_len),
    .high_len_i(high_len),
    .idle_o    (idle),
    .scl_o     (scl_o),
    .low_stb_o (scl_low_o),
    .high_stb_o(scl_high_o)
  );

endmodule

// File: rtl/i2c_scl_gen_chk.sv
`timescale 1ns/1ps
module i2c_scl_gen_chk #(
  parameter int CDF_W      = 3,
  parameter int SCGD_W     = 6,
  parameter int COMP_W     = 5,
  parameter int BASE_TICKS = 20,
  parameter int STEP_TICKS = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_o,
  input logic              scl_o,
  input logic              scl_low_o,
  input logic              scl_high_o,
  input logic              run_i,
  input logic [CDF_W-1:0]  act_cdf_i,
  input logic [SCGD_W-1:0] act_scgd_i,
  input logic [COMP_W-1:0] act_comp_i
);

  logic [CDF_W-1:0] since_q;
  int unsigned      low_ticks_q;
  int unsigned      exp_low;

  assign exp_low = (BASE_TICKS + STEP_TICKS * int'(act_scgd_i) + int'(act_comp_i) + 1) / 2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q <= '0;
    end else if (!run_i || tick_o) begin
      since_q <= '0;
    end else begin
      since_q <= since_q + CDF_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_ticks_q <= 0;
    end else if (scl_o) begin
      low_ticks_q <= 0;
    end else if (tick_o) begin
      low_ticks_q <= low_ticks_q + 1;
    end
  end

  // R2
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (since_q == act_cdf_i));

  // R2
  idle_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !tick_o);

  // R3
  low_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_o) |-> (low_ticks_q == exp_low));

  // R5
  cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i)) |-> ($stable(act_cdf_i) && $stable(act_scgd_i) && $stable(act_comp_i)));

  // R9
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(scl_low_o && scl_high_o));

  // R9
  fall_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scl_o) |-> scl_low_o);

  // R9
  rise_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_o) |-> scl_high_o);

  // R9
  low_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_low_o |=> !scl_low_o);

endmodule

bind i2c_scl_gen i2c_scl_gen_chk #(
  .CDF_W     (CDF_W),
  .SCGD_W    (SCGD_W),
  .COMP_W    (COMP_W),
  .BASE_TICKS(BASE_TICKS),
  .STEP_TICKS(STEP_TICKS)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_o    (tick_o),
  .scl_o     (scl_o),
  .scl_low_o (scl_low_o),
  .scl_high_o(scl_high_o),
  .run_i     (run),
  .act_cdf_i (act_cdf),
  .act_scgd_i(act_scgd),
  .act_comp_i(act_comp)
);

// File: tb/i2c_scl_gen_bench.sv
`timescale 1ns/1ps
module i2c_scl_gen_bench;

  localparam int LIMIT = 20000;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [8:0] cfg_i = '0;
  logic       cfg_we_i = 1'b0;
  logic [4:0] comp_i = '0;
  logic       setup_en_i = 1'b0;
  logic       start_i = 1'b0;
  logic       stop_i = 1'b0;
  logic       tick_o, scl_o, scl_low_o, scl_high_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  i2c_scl_gen u_i2c_scl_gen (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .cfg_i     (cfg_i),
    .cfg_we_i  (cfg_we_i),
    .comp_i    (comp_i),
    .setup_en_i(setup_en_i),
    .start_i   (start_i),
    .stop_i    (stop_i),
    .tick_o    (tick_o),
    .scl_o     (scl_o),
    .scl_low_o (scl_low_o),
    .scl_high_o(scl_high_o)
  );

  task automatic check(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic logic [8:0] mk_cfg(input int cdf, input int scgd);
    return {6'(scgd), 3'(cdf)};
  endfunction

  function automatic int per_ticks(input int scgd, input int comp);
    return 20 + 8 * scgd + comp;
  endfunction

  task automatic clear_pulses();
    cfg_we_i = 1'b0;
    start_i  = 1'b0;
    stop_i   = 1'b0;
  endtask

  // called at a negedge; returns at the first negedge after the START edge
  task automatic do_start(input logic [8:0] cfg, input bit we, input logic [4:0] comp,
                          input bit setup);
    cfg_i = cfg; cfg_we_i = we; comp_i = comp; setup_en_i = setup;
    @(negedge clk);
    cfg_we_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic measure_low(output int cyc, output int tks, output int bad);
    cyc = 0; tks = 0; bad = 0;
    while (!scl_high_o && cyc < LIMIT) begin
      if (tick_o) tks++;
      if (scl_o) bad++;
      cyc++;
      @(negedge clk);
      clear_pulses();
    end
  endtask

  task automatic measure_high(output int cyc, output int bad);
    cyc = 0; bad = 0;
    while (!scl_low_o && cyc < LIMIT) begin
      if (!scl_o) bad++;
      cyc++;
      @(negedge clk);
      clear_pulses();
    end
  endtask

  // called at a high-phase strobe sample
  task automatic drain(input int hl, input int d, input bit do_stop, input string tag);
    int tks = 0;
    int lows = 0;
    if (do_stop) stop_i = 1'b1;
    for (int i = 0; i < hl * d + 20; i++) begin
      if (tick_o) tks++;
      if (scl_low_o || !scl_o) lows++;
      @(negedge clk);
      clear_pulses();
    end
    check(tks, hl, {tag, " ticks in final high phase then idle"});
    check(lows, 0, {tag, " no low phase after stop"});
    check(int'(scl_o), 1, {tag, " scl idle high after stop"});
  endtask

  // R1: reset state and idle without START
  task automatic t_reset();
    int tks = 0;
    int stb = 0;
    @(negedge clk);
    check(int'(scl_o), 1, "R1 scl_o in reset");
    check(int'(tick_o), 0, "R1 tick_o in reset");
    check(int'(scl_low_o | scl_high_o), 0, "R1 strobes in reset");
    rst_ni = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (tick_o) tks++;
      if (scl_low_o || scl_high_o || !scl_o) stb++;
    end
    check(tks, 0, "R1 R2 no tick while idle");
    check(stb, 0, "R1 scl stays high while idle");
  endtask

  // R3 R4 R9: minimum period, divide by one, stop arriving in the high phase
  task automatic t_basic();
    int c, t, b;
    do_start(mk_cfg(0, 0), 1'b1, 5'd0, 1'b0);
    check(int'(scl_low_o), 1, "R9 low strobe right after START");
    check(int'(scl_o), 0, "R9 scl low with strobe");
    measure_low(c, t, b);
    check(c, 10, "R3 low cycles P=20 cdf=0");
    check(t, 10, "R2 ticks in low phase");
    check(b, 0, "R3 scl low throughout low phase");
    check(int'(scl_o), 1, "R9 scl high with high strobe");
    measure_high(c, b);
    check(c, 10, "R3 high cycles P=20 cdf=0");
    check(b, 0, "R3 scl high throughout high phase");
    measure_low(c, t, b);
    check(c, 10, "R3 second low phase");
    drain(10, 1, 1'b1, "R7");
  endtask

  // R3 R2: odd period, divide by three, stop arriving in the low phase
  task automatic t_odd_stop_low();
    int c, t, b;
    // P = 20+8+5 = 33 -> low 17, high 16 ticks, 3 cycles per tick
    do_start(mk_cfg(2, 1), 1'b1, 5'd5, 1'b0);
    stop_i = 1'b1;
    measure_low(c, t, b);
    check(c, 51, "R3 odd period low cycles (R7 stop in low)");
    check(t, 17, "R3 odd tick goes to low phase");
    drain(16, 3, 1'b0, "R7 stop in low");
  endtask

  // R4: field extremes
  task automatic t_extremes();
    int c, t, b;
    // P = 20+504+31 = 555 -> low 278, high 277, 8 cycles per tick
    do_start(mk_cfg(7, 63), 1'b1, 5'd31, 1'b0);
    measure_low(c, t, b);
    check(c, 278 * 8, "R4 low cycles cdf=7 scgd=63");
    check(t, (per_ticks(63, 31) + 1) / 2, "R4 low ticks at max fields");
    measure_high(c, b);
    check(c, 277 * 8, "R4 high cycles cdf=7 scgd=63");
    measure_low(c, t, b);
    drain(277, 8, 1'b1, "R4");
  endtask

  // R5 R8 R10: config, comp and START during a run
  task automatic t_midrun();
    int c, t, b;
    do_start(mk_cfg(0, 0), 1'b1, 5'd0, 1'b0);
    measure_low(c, t, b);
    cfg_i = mk_cfg(1, 2); cfg_we_i = 1'b1; start_i = 1'b1;
    comp_i = 5'd31; setup_en_i = 1'b1;
    measure_high(c, b);
    check(c, 10, "R8 START while running ignored");
    measure_low(c, t, b);
    check(c, 10, "R5 config write deferred during run");
    check(t, 10, "R10 comp change ignored during run");
    drain(10, 1, 1'b1, "R5");
    // pending word applies now: P = 20+16+3 = 39 -> low 20, high 19, 2 cycles per tick
    do_start(mk_cfg(0, 0), 1'b0, 5'd3, 1'b0);
    measure_low(c, t, b);
    check(c, 40, "R5 pending config applied at next START");
    check(t, 20, "R10 comp sampled at START");
    measure_high(c, b);
    check(c, 38, "R5 high cycles with new config");
    measure_low(c, t, b);
    drain(19, 2, 1'b1, "R5");
  endtask

  // R6: first-edge setup delay
  task automatic t_setup();
    int c, t, b;
    do_start(mk_cfg(1, 0), 1'b1, 5'd0, 1'b1);
    check(int'(scl_low_o), 0, "R6 no low strobe at START with setup");
    measure_high(c, b);
    check(c, 34, "R6 setup lasts 17 ticks");
    check(b, 0, "R6 scl high during setup");
    measure_low(c, t, b);
    check(c, 20, "R6 first low after setup");
    measure_high(c, b);
    check(c, 20, "R6 high phase after setup");
    measure_low(c, t, b);
    check(c, 20, "R6 no setup delay on later period");
    drain(10, 2, 1'b1, "R6");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_odd_stop_low();
    t_extremes();
    t_midrun();
    t_setup();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule